// File: doc/BRIEF.md
# Fly-by Four-Channel DMA Controller

This block moves blocks of bytes between I/O devices and memory. The data never passes through the controller. Software programs each of four channels with three things: a direction, a starting memory address and a transfer length. A write to a channel arms it. When a device raises its request line on an armed channel, the controller asks the processor for the bus. It waits for the processor's hold acknowledge and then acknowledges the device. After that it moves one byte per clock.

In each byte cycle the controller drives the memory address and asserts a memory strobe together with the opposite I/O strobe. The memory and the device then exchange the byte directly over the shared data bus. The address rises and the remaining count falls after every byte.

When the count expires, the controller gives the bus back and latches a per-channel terminal-count flag. That flag drives the interrupt until software reads the status. If a device withdraws its request partway through a block, the controller parks the channel and later resumes from where it stopped.

Top module: `dma_flyby_top`

## Requirements
- R1: Exactly one channel is active at a time and at most one `dack` bit is high. When several armed channels request together, the lowest-numbered one is served first. A new channel is chosen only while the bus is released, never in the middle of a block.
- R2: A cycle with `cfg_we` high loads `cfg_to_dev`, `cfg_addr` and `cfg_cnt` into channel `cfg_ch` and arms that channel. A channel that has not been armed never raises `hrq`, whatever its `dreq` does.
- R3: An armed channel with `dreq` high sampled at a clock edge makes `hrq` high from that edge. `hrq` then stays high until the block ends or pauses.
- R4: `dack` and all four strobes stay low until `hlda` has been sampled high. While `hlda` is held low, `hrq` remains asserted and no byte moves.
- R5: With `cfg_to_dev`=1 each byte cycle asserts `mem_rd` and `io_wr` together (memory to device). With `cfg_to_dev`=0 it asserts `io_rd` and `mem_wr` together (device to memory). One byte moves per clock while `dack` is high.
- R6: `bus_addr` starts at the programmed address and rises by one per byte. A programmed count of N moves exactly N+1 bytes. After the last byte, `hrq` drops.
- R7: Completion sets the channel's bit in `stat_tc` (bit i = channel i), and `irq` is high while any bit is set. A cycle with `stat_rd` high clears all bits at the next edge.
- R8: If `dreq` falls during a block, the byte in progress finishes and `hrq` drops. A later request resumes from the next address with the remaining count, so the whole block stays contiguous and completes once.
- R9: A completed channel is disarmed. Its `dreq` is ignored (no `hrq`) until the channel is programmed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Program channel strobe |
| cfg_ch | input | 2 | Channel being programmed |
| cfg_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| cfg_addr | input | 16 | Starting memory address |
| cfg_cnt | input | 16 | Byte count minus one |
| stat_rd | input | 1 | Status read; clears terminal-count flags |
| stat_tc | output | 4 | Per-channel terminal-count flags |
| irq | output | 1 | Completion interrupt |
| dreq | input | 4 | Device request per channel |
| dack | output | 4 | Device acknowledge per channel |
| hrq | output | 1 | Bus hold request to processor |
| hlda | input | 1 | Bus hold acknowledge from processor |
| bus_addr | output | 16 | Memory address during byte cycles |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
A request raised between edges shows on `hrq` right after the next rising edge. The bench models the processor's acknowledge with a two-register delay, so `hlda` arrives two edges after `hrq`. The first byte cycle starts at the edge after that, and each later byte takes one edge. Flags and `irq` change at the edge of the final byte. `stat_rd` clears them one edge later.

The bench drives all inputs and samples all outputs on falling edges, so every value it reads has settled after the edge that produced it. A falling-edge monitor logs each strobe cycle with its channel, address and strobe pair. Each check waits, with a bounded loop, for the condition it depends on before it reads the log.

// File: rtl/dma_flyby_pkg.sv
package dma_flyby_pkg;
    parameter int NCH = 4;
    parameter int AW  = 16;
    parameter int CW  = 16;
    localparam int CHW = $clog2(NCH);

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_MOVE, S_REL} seq_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          to_dev;
        logic          armed;
    } chan_t;

    function automatic logic [NCH-1:0] ch_onehot(logic [CHW-1:0] c);
        return {{(NCH-1){1'b0}}, 1'b1} << c;
    endfunction
endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dma_flyby_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [CHW-1:0]         wr_ch,
    input  logic                   wr_to_dev,
    input  logic [AW-1:0]          wr_addr,
    input  logic [CW-1:0]          wr_cnt,
    input  logic                   step,
    input  logic                   done,
    input  logic [CHW-1:0]         act_ch,
    input  logic                   stat_rd,
    output chan_t [NCH-1:0]        chans,
    output logic  [NCH-1:0]        tc_q
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                chans[g] <= '0;
            end else if (wr_en && wr_ch == CHW'(g)) begin
                chans[g].addr   <= wr_addr;
                chans[g].cnt    <= wr_cnt;
                chans[g].to_dev <= wr_to_dev;
                chans[g].armed  <= 1'b1;
            end else if (step && act_ch == CHW'(g)) begin
                chans[g].addr <= chans[g].addr + AW'(1);
                chans[g].cnt  <= chans[g].cnt - CW'(1);
                if (done) chans[g].armed <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)                              tc_q[g] <= 1'b0;
            else if (done && act_ch == CHW'(g))   tc_q[g] <= 1'b1;
            else if (stat_rd)                     tc_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
    import dma_flyby_pkg::*;
(
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_flyby_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           pend_any,
    input  logic [CHW-1:0] pend_idx,
    input  logic           hlda,
    input  logic           dreq_cur,
    input  logic           cnt_zero,
    output seq_t           st,
    output logic [CHW-1:0] cur,
    output logic           step,
    output logic           done
);
    assign step = (st == S_MOVE);
    assign done = step && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cur <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (pend_any) begin
                    cur <= pend_idx;
                    st  <= S_WAIT;
                end
                S_WAIT: begin
                    if (!dreq_cur)  st <= S_REL;
                    else if (hlda)  st <= S_MOVE;
                end
                S_MOVE: if (cnt_zero || !dreq_cur) st <= S_REL;
                S_REL:  if (!hlda) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_flyby_top.sv
module dma_flyby_top
    import dma_flyby_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic           cfg_to_dev,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [CW-1:0]  cfg_cnt,
    input  logic           stat_rd,
    output logic [NCH-1:0] stat_tc,
    output logic           irq,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack,
    output logic           hrq,
    input  logic           hlda,
    output logic [AW-1:0]  bus_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           io_rd,
    output logic           io_wr
);
    chan_t [NCH-1:0] chans;
    logic  [NCH-1:0] armed_v;
    logic            pend_any, step, done;
    logic [CHW-1:0]  pend_idx, cur;
    seq_t            st;

    for (genvar g = 0; g < NCH; g++) begin : g_arm
        assign armed_v[g] = chans[g].armed;
    end

    dma_chan_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_ch(cfg_ch),
        .wr_to_dev(cfg_to_dev), .wr_addr(cfg_addr), .wr_cnt(cfg_cnt),
        .step(step), .done(done), .act_ch(cur), .stat_rd(stat_rd),
        .chans(chans), .tc_q(stat_tc)
    );

    dma_prio_pick u_pick (
        .req(dreq & armed_v), .any(pend_any), .idx(pend_idx)
    );

    dma_seq u_seq (
        .clk(clk), .rst(rst), .pend_any(pend_any), .pend_idx(pend_idx),
        .hlda(hlda), .dreq_cur(dreq[cur]), .cnt_zero(chans[cur].cnt == '0),
        .st(st), .cur(cur), .step(step), .done(done)
    );

    assign hrq      = (st == S_WAIT) || (st == S_MOVE);
    assign dack     = step ? ch_onehot(cur) : '0;
    assign bus_addr = step ? chans[cur].addr : '0;
    assign mem_rd   = step &&  chans[cur].to_dev;
    assign io_wr    = step &&  chans[cur].to_dev;
    assign io_rd    = step && !chans[cur].to_dev;
    assign mem_wr   = step && !chans[cur].to_dev;
    assign irq      = |stat_tc;
endmodule

// File: rtl/dma_flyby_chk.sv
module dma_flyby_chk
    import dma_flyby_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] dack,
    input logic           hrq,
    input logic           hlda,
    input logic [AW-1:0]  bus_addr,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr
);
    logic any_strobe;
    assign any_strobe = mem_rd | mem_wr | io_rd | io_wr;

    p_one_dack_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    p_strobe_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> (hlda && hrq && dack != '0));

    p_pair_r5: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> ($countones({mem_rd, mem_wr, io_rd, io_wr}) == 2
                        && (mem_rd == io_wr)));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (any_strobe && $past(any_strobe) && dack == $past(dack) && !$past(rst))
        |-> bus_addr == $past(bus_addr) + AW'(1));

    p_hrq_from_req_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(hrq) && !$past(rst)) |-> $past(dreq) != '0);

    p_hold_during_block_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(any_strobe) && any_strobe && !$past(rst)) |-> hrq);
endmodule

bind dma_flyby_top dma_flyby_chk u_chk (
    .clk(clk), .rst(rst), .dreq(dreq), .dack(dack), .hrq(hrq), .hlda(hlda),
    .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr)
);

// File: tb/dma_flyby_top_tb.sv
module dma_flyby_top_tb;
    logic        clk = 1'b0, rst = 1'b1;
    logic        cfg_we = 0, cfg_to_dev = 0, stat_rd = 0;
    logic [1:0]  cfg_ch = 0;
    logic [15:0] cfg_addr = 0, cfg_cnt = 0;
    logic [3:0]  stat_tc, dreq = 0, dack;
    logic        irq, hrq, hlda, mem_rd, mem_wr, io_rd, io_wr;
    logic [15:0] bus_addr;
    logic        ack_en = 1'b1, hq1;

    int errors = 0, checks = 0, nbytes = 0;
    logic [1:0]  log_ch  [0:255];
    logic [15:0] log_addr[0:255];
    logic        log_tod [0:255];
    logic        log_bad [0:255];

    always #5 clk = ~clk;

    dma_flyby_top u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_to_dev(cfg_to_dev), .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt),
        .stat_rd(stat_rd), .stat_tc(stat_tc), .irq(irq), .dreq(dreq),
        .dack(dack), .hrq(hrq), .hlda(hlda), .bus_addr(bus_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
    );

    // processor model: acknowledge two edges after request
    always @(posedge clk) begin
        if (rst) begin hq1 <= 1'b0; hlda <= 1'b0; end
        else begin hq1 <= hrq & ack_en; hlda <= hq1; end
    end

    // byte monitor
    always @(negedge clk) begin
        if (!rst && (mem_rd | mem_wr | io_rd | io_wr) && nbytes < 256) begin
            log_ch[nbytes]   <= (dack == 4'b0010) ? 2'd1 : (dack == 4'b0100) ? 2'd2 :
                                (dack == 4'b1000) ? 2'd3 : 2'd0;
            log_addr[nbytes] <= bus_addr;
            log_tod[nbytes]  <= mem_rd;
            log_bad[nbytes]  <= !((mem_rd && io_wr && !mem_wr && !io_rd) ||
                                  (io_rd && mem_wr && !mem_rd && !io_wr)) || !hlda;
            nbytes <= nbytes + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic program_ch(input int ch, input bit tod, input int addr, input int cnt);
        @(negedge clk);
        cfg_we = 1; cfg_ch = 2'(ch); cfg_to_dev = tod;
        cfg_addr = 16'(addr); cfg_cnt = 16'(cnt);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wait_tc(input logic [3:0] mask);
        for (int i = 0; i < 300; i++) begin
            if ((stat_tc & mask) == mask) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50; i++) begin
            if (!hrq && !hlda) break;
            @(negedge clk);
        end
    endtask

    task automatic clear_status();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic check_block(input int base, input int n, input int ch,
                               input int addr, input bit tod, input string req);
        bit ok = 1;
        int bad_i = -1;
        for (int i = 0; i < n; i++) begin
            if (log_ch[base+i] != 2'(ch) || log_addr[base+i] != 16'(addr + i) ||
                log_tod[base+i] != tod || log_bad[base+i]) begin
                if (bad_i < 0) bad_i = i;
                ok = 0;
            end
        end
        check(ok, req, "byte log", bad_i < 0 ? 0 : int'(log_addr[base+bad_i]),
              bad_i < 0 ? 0 : addr + bad_i);
    endtask

    task automatic t_reset();
        check(hrq == 0 && dack == 0 && !mem_rd && !mem_wr && !io_rd && !io_wr,
              "R4", "bus idle after reset", {hrq, dack}, 0);
        check(stat_tc == 0 && irq == 0, "R7", "status after reset", {stat_tc, irq}, 0);
    endtask

    task automatic t_mem_to_dev();
        int base = nbytes;
        program_ch(1, 1, 'h0100, 3);
        @(negedge clk); dreq[1] = 1;
        @(negedge clk);
        check(hrq == 1, "R3", "hrq one edge after dreq", hrq, 1);
        check(dack == 0, "R4", "no dack before hlda", dack, 0);
        wait_tc(4'b0010);
        dreq[1] = 0;
        wait_idle();
        check(nbytes - base == 4, "R6", "count 3 moves 4 bytes", nbytes - base, 4);
        check_block(base, 4, 1, 'h0100, 1, "R5");
        check(stat_tc == 4'b0010 && irq, "R7", "tc flag and irq", {stat_tc, irq}, 5'b00101);
        clear_status();
        check(stat_tc == 0 && !irq, "R7", "status read clears", {stat_tc, irq}, 0);
    endtask

    task automatic t_no_ack();
        int base = nbytes;
        ack_en = 0;
        program_ch(0, 0, 'h0200, 1);
        dreq[0] = 1;
        repeat (10) @(negedge clk);
        check(hrq == 1 && nbytes == base && dack == 0, "R4", "stall without hlda",
              nbytes - base, 0);
        ack_en = 1;
        wait_tc(4'b0001);
        dreq[0] = 0;
        wait_idle();
        check_block(base, 2, 0, 'h0200, 0, "R5");
        check(nbytes - base == 2, "R6", "two bytes after late ack", nbytes - base, 2);
        clear_status();
    endtask

    task automatic t_single();
        int base = nbytes;
        program_ch(2, 0, 'hFFFF, 0);
        dreq[2] = 1;
        wait_tc(4'b0100);
        dreq[2] = 0;
        wait_idle();
        check(nbytes - base == 1, "R6", "count 0 moves one byte", nbytes - base, 1);
        check_block(base, 1, 2, 'hFFFF, 0, "R5");
        clear_status();
    endtask

    task automatic t_priority();
        int base = nbytes;
        program_ch(3, 1, 'h3000, 1);
        program_ch(0, 0, 'h0400, 1);
        @(negedge clk); dreq = 4'b1001;
        wait_tc(4'b1001);
        dreq = 0;
        wait_idle();
        check(nbytes - base == 4, "R1", "both blocks moved", nbytes - base, 4);
        check_block(base, 2, 0, 'h0400, 0, "R1");
        check_block(base + 2, 2, 3, 'h3000, 1, "R1");
        clear_status();
    endtask

    task automatic t_pause();
        int base = nbytes;
        bit dropped = 0;
        program_ch(1, 0, 'h0500, 7);
        dreq[1] = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (nbytes - base >= 3) break;
        end
        dreq[1] = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!hrq) begin dropped = 1; break; end
        end
        check(dropped && stat_tc == 0, "R8", "paused without completing", stat_tc, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        dreq[1] = 1;
        wait_tc(4'b0010);
        dreq[1] = 0;
        wait_idle();
        check(nbytes - base == 8, "R8", "resumed total bytes", nbytes - base, 8);
        check_block(base, 8, 1, 'h0500, 0, "R8");
        clear_status();
    endtask

    task automatic t_disarmed();
        int base = nbytes;
        bit seen = 0;
        dreq = 4'b0110;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (hrq) seen = 1;
        end
        check(!seen && nbytes == base, "R9", "done channels ignore dreq", seen, 0);
        dreq = 0;
        @(negedge clk);
        check(!hrq, "R2", "unarmed channel never requests", hrq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_mem_to_dev();
        t_no_ack();
        t_single();
        t_priority();
        t_pause();
        t_disarmed();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule